// File: doc/BRIEF.md
# Bar-Graph Column Raster Writer

This block turns a page of eight bar heights into the pixel rows of one character-cell column of a monochrome spectrum display. A producer fills a small two-page height buffer and then raises `run_i`. The block then reads the selected page into its own registers. After that it walks a threshold down from the top of the graph to its bottom row. On each step it writes one byte to video memory. Bit *i* of that byte says whether bar *i* reaches the current row.

The video memory is organised as 8-pixel-wide, 12-row character cells. The low four address bits give the row inside a cell. The bits above them give the cell column and the cell row. The sender identifier picks the upper or lower half of the screen, and a blank cell row is left as a margin at the top of each half. The block raises one write-enable pulse per row and never stalls. The buffer is read combinationally, so a full job takes a fixed number of cycles.

Top module: `bar_raster_writer`

## Requirements
- R1: After reset the block is idle. A job starts only on a 0-to-1 transition of `run_i` seen while idle. At that edge it captures `sender_i`, `page_i` and `col_i`, and later changes to these inputs do not affect the job in progress.
- R2: A job first spends 8 cycles reading the height buffer. In load cycle n (n = 0..7), `buf_addr_o` = {captured page, n[2:0]}, and no video write occurs. The heights are held internally, so buffer changes after the read-in do not alter the output.
- R3: The read-in is followed by exactly 72 video writes on consecutive cycles, one `vid_we_o` cycle each. The block then returns to idle. `busy_o` is high for exactly 80 cycles per job.
- R4: Write k (k = 0..71) uses threshold t = 72 - k. Output bit i is 1 exactly when height i >= t. A height of 0 is never drawn, and a height of 72 or more lights every row.
- R5: Bit i of `vid_data_o` (bit 0 = LSB) comes from buffer entry i of the selected page.
- R6: For write k, `vid_addr_o[3:0]` = k mod 12 and `vid_addr_o[8:4]` = the captured column. `vid_addr_o[12:9]` = B + k div 12, where B = 1 for sender 0 and B = 9 for sender 1. The first write is therefore the top row of the graph, at the lowest address.
- R7: A rising `run_i` while busy is ignored, and holding `run_i` high does not start a second job.
- R8: During reset `busy_o` and `vid_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Job request; a rising edge starts a job |
| sender_i | input | 1 | Screen half: 0 = upper, 1 = lower |
| page_i | input | 1 | Height buffer page to draw |
| col_i | input | 5 | Character-cell column to draw into |
| buf_addr_o | output | 4 | Height buffer read address {page, entry} |
| buf_data_i | input | 8 | Height read from buffer (same cycle) |
| vid_we_o | output | 1 | Video memory write strobe |
| vid_addr_o | output | 13 | Video memory address {cell row, column, row in cell} |
| vid_data_o | output | 8 | Row byte, one bit per bar |
| busy_o | output | 1 | Job in progress |

## Verification
The assertions assume that the height buffer answers within the same cycle, and that it presents the entry at `buf_addr_o` while the read-in is running. They also assume that reset is held long enough for the edge detector to settle. The bench models the buffer as a combinational array indexed by the address port. It changes buffer contents only after the read-in window, so the captured heights can be told apart from the live ones. Job inputs are scrambled and `run_i` is pulsed only while a job is running. This keeps every stimulus inside the handshake the block expects, while still exercising the capture and ignore rules.

// File: rtl/bar_raster_pkg.sv
package bar_raster_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_DRAW = 2'd2
   } ctl_state_t;
endpackage

// File: rtl/bar_page_loader.sv
module bar_page_loader #(
   parameter int BARS  = 8,
   parameter int HGT_W = 8,
   localparam int IDX_W = $clog2(BARS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic [IDX_W-1:0]      idx_i,
   input  logic [HGT_W-1:0]      data_i,
   output logic [BARS*HGT_W-1:0] heights_o
);
   generate
      if (BARS < 2 || (1 << IDX_W) != BARS) begin : g_bad_bars
         $error("bar_page_loader: BARS must be a power of two >= 2");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < BARS; gi++) begin : g_slot
         logic [HGT_W-1:0] hgt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hgt_q <= '0;
            end else if (load_i && idx_i == IDX_W'(gi)) begin
               hgt_q <= data_i;
            end
         end
         assign heights_o[gi*HGT_W +: HGT_W] = hgt_q;
      end
   endgenerate
endmodule

// File: rtl/bar_row_slicer.sv
module bar_row_slicer #(
   parameter int BARS  = 8,
   parameter int HGT_W = 8,
   parameter int CNT_W = 7
) (
   input  logic [BARS*HGT_W-1:0] heights_i,
   input  logic [CNT_W-1:0]      thresh_i,
   output logic [BARS-1:0]       row_o
);
   generate
      if (CNT_W > 31 || HGT_W > 31) begin : g_bad_width
         $error("bar_row_slicer: widths must stay below 32 bits");
      end
   endgenerate

   genvar gb;
   generate
      for (gb = 0; gb < BARS; gb++) begin : g_cmp
         assign row_o[gb] = (32'(heights_i[gb*HGT_W +: HGT_W]) >= 32'(thresh_i));
      end
   endgenerate
endmodule

// File: rtl/cell_addr_gen.sv
module cell_addr_gen #(
   parameter int CELL_H = 12,
   parameter int RIC_W  = 4,
   parameter int CROW_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_i,
   input  logic [CROW_W-1:0] base_i,
   input  logic              step_i,
   output logic [RIC_W-1:0]  ric_o,
   output logic [CROW_W-1:0] crow_o
);
   localparam logic [RIC_W-1:0] RIC_LAST = RIC_W'(CELL_H - 1);

   generate
      if (CELL_H < 2 || CELL_H > (1 << RIC_W)) begin : g_bad_cell
         $error("cell_addr_gen: CELL_H must fit in RIC_W bits");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ric_o  <= '0;
         crow_o <= '0;
      end else if (init_i) begin
         ric_o  <= '0;
         crow_o <= base_i;
      end else if (step_i) begin
         if (ric_o == RIC_LAST) begin
            ric_o  <= '0;
            crow_o <= crow_o + CROW_W'(1);
         end else begin
            ric_o <= ric_o + RIC_W'(1);
         end
      end
   end

   assert_ric_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      32'(ric_o) < CELL_H);

   assert_ric_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !init_i && ric_o == RIC_LAST) |=> (ric_o == '0 && crow_o == CROW_W'($past(crow_o) + 1'b1)));
endmodule

// File: rtl/bar_raster_writer.sv
module bar_raster_writer
   import bar_raster_pkg::*;
#(
   parameter int BARS       = 8,
   parameter int DATA_W     = 8,
   parameter int CELL_H     = 12,
   parameter int HEIGHT     = 72,
   parameter int COL_W      = 5,
   parameter int CROW_W     = 4,
   parameter int RIC_W      = 4,
   parameter int HALF_CELLS = 8,
   parameter int MARGIN     = 1,
   localparam int IDX_W  = $clog2(BARS),
   localparam int CNT_W  = $clog2(HEIGHT + 1),
   localparam int BADR_W = IDX_W + 1,
   localparam int VADR_W = CROW_W + COL_W + RIC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              sender_i,
   input  logic              page_i,
   input  logic [COL_W-1:0]  col_i,
   output logic [BADR_W-1:0] buf_addr_o,
   input  logic [DATA_W-1:0] buf_data_i,
   output logic              vid_we_o,
   output logic [VADR_W-1:0] vid_addr_o,
   output logic [DATA_W-1:0] vid_data_o,
   output logic              busy_o
);
   localparam logic [CROW_W-1:0] BASE_TOP = CROW_W'(MARGIN);
   localparam logic [CROW_W-1:0] BASE_BOT = CROW_W'(HALF_CELLS + MARGIN);
   localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(BARS - 1);

   generate
      if (BARS != DATA_W) begin : g_bad_bars
         $error("bar_raster_writer: one bit per bar requires BARS == DATA_W");
      end
      if (HEIGHT != (HALF_CELLS - 2 * MARGIN) * CELL_H) begin : g_bad_height
         $error("bar_raster_writer: HEIGHT must fill a half minus its margins");
      end
      if (2 * HALF_CELLS > (1 << CROW_W)) begin : g_bad_rows
         $error("bar_raster_writer: CROW_W too small for two halves");
      end
   endgenerate

   ctl_state_t        state;
   logic              run_q;
   logic              sender_q;
   logic              page_q;
   logic [COL_W-1:0]  col_q;
   logic [IDX_W-1:0]  idx;
   logic [CNT_W-1:0]  cnt;
   logic              start;
   logic [BARS*DATA_W-1:0] heights;
   logic [RIC_W-1:0]  ric;
   logic [CROW_W-1:0] crow;
   logic [BARS-1:0]   row_bits;

   assign start = (state == ST_IDLE) && run_i && !run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         run_q    <= 1'b0;
         sender_q <= 1'b0;
         page_q   <= 1'b0;
         col_q    <= '0;
         idx      <= '0;
         cnt      <= '0;
      end else begin
         run_q <= run_i;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  sender_q <= sender_i;
                  page_q   <= page_i;
                  col_q    <= col_i;
                  idx      <= '0;
                  state    <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               idx <= idx + IDX_W'(1);
               if (idx == IDX_LAST) begin
                  cnt   <= CNT_W'(HEIGHT);
                  state <= ST_DRAW;
               end
            end
            ST_DRAW: begin
               cnt <= cnt - CNT_W'(1);
               if (cnt == CNT_W'(1)) begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign buf_addr_o = {page_q, idx};

   bar_page_loader #(.BARS(BARS), .HGT_W(DATA_W)) u_loader (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (state == ST_LOAD),
      .idx_i     (idx),
      .data_i    (buf_data_i),
      .heights_o (heights)
   );

   bar_row_slicer #(.BARS(BARS), .HGT_W(DATA_W), .CNT_W(CNT_W)) u_slicer (
      .heights_i (heights),
      .thresh_i  (cnt),
      .row_o     (row_bits)
   );

   cell_addr_gen #(.CELL_H(CELL_H), .RIC_W(RIC_W), .CROW_W(CROW_W)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .init_i (state == ST_LOAD),
      .base_i (sender_q ? BASE_BOT : BASE_TOP),
      .step_i (state == ST_DRAW),
      .ric_o  (ric),
      .crow_o (crow)
   );

   assign vid_we_o   = (state == ST_DRAW);
   assign vid_addr_o = {crow, col_q, ric};
   assign vid_data_o = row_bits;
   assign busy_o     = (state != ST_IDLE);

   assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DRAW && $past(state) == ST_DRAW) |-> cnt == CNT_W'($past(cnt) - 1'b1));

   assert_load_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DRAW && $past(state) == ST_LOAD) |-> $past(idx) == IDX_LAST);

   assert_last_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_we_o && cnt == CNT_W'(1)) |=> (!vid_we_o && !busy_o));

   assert_ignore_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && run_i) |=> ($stable(page_q) && $stable(col_q) && $stable(sender_q)));

   assert_first_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_we_o && cnt == CNT_W'(HEIGHT)) |-> (ric == '0 && (crow == BASE_TOP || crow == BASE_BOT)));
endmodule

// File: tb/bar_raster_writer_tb.sv
module bar_raster_writer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_i = 1'b0;
   logic        sender_i = 1'b0;
   logic        page_i = 1'b0;
   logic [4:0]  col_i = '0;
   logic [3:0]  buf_addr_o;
   logic [7:0]  buf_data_i;
   logic        vid_we_o;
   logic [12:0] vid_addr_o;
   logic [7:0]  vid_data_o;
   logic        busy_o;

   logic [7:0] mem [16];
   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign buf_data_i = mem[buf_addr_o];

   bar_raster_writer u_dut (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .sender_i(sender_i),
      .page_i(page_i), .col_i(col_i), .buf_addr_o(buf_addr_o),
      .buf_data_i(buf_data_i), .vid_we_o(vid_we_o), .vid_addr_o(vid_addr_o),
      .vid_data_o(vid_data_o), .busy_o(busy_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic run_job(input bit snd, input bit pg, input int col, input bit pulse_mid);
      logic [7:0] hv [8];
      int k = 0;
      int busy_n = 0;
      for (int i = 0; i < 8; i++) hv[i] = mem[{pg, 3'(i)}];
      @(negedge clk);
      sender_i = snd; page_i = pg; col_i = 5'(col); run_i = 1'b1;
      @(negedge clk);
      sender_i = ~snd; page_i = ~pg; col_i = ~5'(col);  // R1 captured values only
      for (int c = 0; c < 100; c++) begin
         if (c == 20) for (int i = 0; i < 16; i++) mem[i] = 8'(~mem[i]);  // R2 held heights
         if (pulse_mid && c == 30) run_i = 1'b0;
         if (pulse_mid && c == 31) run_i = 1'b1;  // R7 rise while busy
         if (busy_o) busy_n++;
         if (c < 8) begin
            chk("R2 load no write", int'(vid_we_o), 0);
            chk("R2 buf addr", int'(buf_addr_o), pg * 8 + c);
         end
         if (vid_we_o) begin
            int t = 72 - k;
            int ed = 0;
            int ea;
            for (int i = 0; i < 8; i++) if (int'(hv[i]) >= t) ed |= (1 << i);
            ea = (((snd ? 9 : 1) + k / 12) << 9) | (col << 4) | (k % 12);
            chk("R4 R5 row byte", int'(vid_data_o), ed);
            chk("R6 address", int'(vid_addr_o), ea);
            chk("R3 consecutive", c, 8 + k);
            k++;
         end
         @(negedge clk);
      end
      chk("R3 write count", k, 72);
      chk("R3 busy cycles", busy_n, 80);
      chk("R7 idle after job", int'(busy_o), 0);
      run_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R1 no spurious start", int'(busy_o), 0);
   endtask

   initial begin
      wait (cyc >= 150000);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 8'(i * 5);
      run_i = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk("R8 reset busy", int'(busy_o), 0);
         chk("R8 reset we", int'(vid_we_o), 0);
      end
      run_i = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", int'(busy_o), 0);
      // corner heights: 0, 1, 71, 72, 73, 255, mid values
      mem[0] = 0;  mem[1] = 1;  mem[2] = 71; mem[3] = 72;
      mem[4] = 73; mem[5] = 255; mem[6] = 36; mem[7] = 12;
      run_job(1'b0, 1'b0, 0, 1'b0);
      for (int i = 0; i < 8; i++) begin
         mem[i] = 8'(8 * i + 1); mem[8 + i] = 8'(72 - 9 * i);
      end
      run_job(1'b1, 1'b1, 31, 1'b1);
      for (int j = 0; j < 12; j++) begin
         for (int a = 0; a < 16; a++) mem[a] = 8'((a * 37 + j * 53) % 90);
         run_job(1'(j % 2), 1'((j / 2) % 2), (j * 7 + 3) % 32, 1'(j % 3 == 0));
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule